// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block watches over a processor by counting system clocks through a chain of binary dividers. Software picks one of eight divider taps with a 3-bit select field. That tap feeds a fixed base counter, and when the whole chain rolls over the block reports a time-out. A healthy program restarts the chain before it expires by writing a clear strobe into the control register. If the program stops doing this, the time-out fires. When the enable bit is set, the time-out also raises a fixed-length reset request to the chip's reset logic.

The counter runs freely whether or not the enable bit is set, so the block can also serve as a periodic time base. A one-cycle expiry pulse marks every roll-over. A separate control bit decides whether counting goes on while the processor reports that it is idle, or freezes until the idle input drops.

The control register sits on a simple byte-wide special-function-register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `wdt_guard`

## Requirements
- R1: After reset the control register reads 00h, and both `expire_o` and `rst_req_o` are low.
- R2: The control register at address 8Fh holds the enable in bit 7, the idle-run bit in bit 5 and the tap select PS in bits 2:0. Bit 6 (the clear strobe) and bits 4:3 always read 0. A read of any other address returns 00h, and a write to any other address leaves the register unchanged.
- R3: Counted from the clock edge that restarts the chain, the time-out falls on advance number 2^(BASE_W+1+PS). Here BASE_W is the width of the base counter (14 by default, giving 2^(15+PS)). `expire_o` is high in the cycle that follows that advance edge.
- R4: A write to 8Fh with bit 6 set restarts the chain from zero, whatever the other bits hold.
- R5: With the idle-run bit at 0, a cycle with `idle_i` high does not advance the chain. With the idle-run bit at 1, every cycle advances it.
- R6: `expire_o` is a single-cycle pulse. After a time-out the chain starts over and expires again after another full interval.
- R7: A time-out with the enable bit set raises `rst_req_o` for exactly RST_LEN (24) cycles, starting in the same cycle as `expire_o`. The enable bit reads 0 afterwards.
- R8: A time-out with the enable bit clear leaves `rst_req_o` low.
- R9: A write that sets bit 7 and carries a PS value different from the stored one restarts the chain.
- R10: A write with bit 6 clear that leaves PS unchanged does not disturb the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| idle_i | input | 1 | High while the processor is in idle mode |
| sfr_addr | input | 8 | Register port address |
| sfr_we | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data, combinational |
| expire_o | output | 1 | One-cycle pulse on each time-out |
| rst_req_o | output | 1 | Reset request, RST_LEN cycles long |

## Verification
Expiry is timed under four tap selects with the idle input held low, which separates an off-by-one in the tap decode from a wrong exponent. Idle patterns with a random density are then applied under both settings of the idle-run bit. Where the chain should freeze, only a count of non-idle cycles predicts the expiry cycle, so freezing cannot be confused with continuing. Mid-interval writes contrast a clear strobe, a plain rewrite of the same value and a select change while enabled: only the first and last must move the expiry point. Randomized runs then mix tap select, idle density and enable together.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  // Register layout: these positions are decoded by software
  localparam int PS_W     = 3;
  localparam int BIT_EN   = 7;
  localparam int BIT_CLR  = 6;
  localparam int BIT_IRUN = 5;

  typedef struct packed {
    logic            en;
    logic            irun;
    logic [PS_W-1:0] ps;
  } wdt_cfg_t;

endpackage

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_we,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic              kill_i,
  output wdt_cfg_t          cfg_o,
  output logic              restart_o
);

  wdt_cfg_t cfg_q, cfg_d;
  logic     sel, wr_hit;
  logic     unused_wbits;

  assign sel          = (sfr_addr == CTRL_ADDR);
  assign wr_hit       = sfr_we && sel;
  assign unused_wbits = ^sfr_wdata[4:3];

  // next-state
  always_comb begin
    cfg_d = cfg_q;
    if (wr_hit) begin
      cfg_d.en   = sfr_wdata[BIT_EN];
      cfg_d.irun = sfr_wdata[BIT_IRUN];
      cfg_d.ps   = sfr_wdata[PS_W-1:0];
    end
    if (kill_i) cfg_d.en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // clear strobe, or select change while enabling
  assign restart_o = wr_hit &&
                     (sfr_wdata[BIT_CLR] ||
                      (sfr_wdata[BIT_EN] && (sfr_wdata[PS_W-1:0] != cfg_q.ps)));

  always_comb begin
    sfr_rdata = '0;
    if (sel) begin
      sfr_rdata[BIT_EN]     = cfg_q.en;
      sfr_rdata[BIT_IRUN]   = cfg_q.irun;
      sfr_rdata[PS_W-1:0]   = cfg_q.ps;
    end
  end

  assign cfg_o = cfg_q;

  a_r7_enable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !cfg_q.en);

endmodule

// File: rtl/wdt_guard_chain.sv
module wdt_guard_chain #(
  parameter int BASE_W = 14,
  parameter int PS_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic            restart_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tmo_hit_o
);

  localparam int NTAPS = 1 << PS_W;

  logic [NTAPS-1:0]  pre_q, pre_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [NTAPS-1:0]  tap;
  logic              pre_tick;

  // tap k goes high once every 2^(k+1) advances
  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    assign tap[k] = &pre_q[k:0];
  end

  assign pre_tick  = adv_i && tap[ps_i];
  assign tmo_hit_o = pre_tick && (&base_q);

  always_comb begin
    pre_d  = pre_q;
    base_d = base_q;
    if (restart_i) begin
      pre_d  = '0;
      base_d = '0;
    end else if (adv_i) begin
      pre_d = tmo_hit_o ? '0 : pre_q + 1'b1;
      if (pre_tick) base_d = base_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      base_q <= '0;
    end else begin
      pre_q  <= pre_d;
      base_q <= base_d;
    end
  end

  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (pre_q == '0) && (base_q == '0));

  a_r5_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !restart_i) |=> $stable(pre_q) && $stable(base_q));

endmodule

// File: rtl/wdt_guard_rstgen.sv
module wdt_guard_rstgen #(
  parameter int LEN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic req_o
);

  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (trig_i)              cnt_d = CW'(LEN);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign req_o = (cnt_q != '0);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int BASE_W      = 14,
  parameter int RST_LEN     = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_i,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_we,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  output logic       expire_o,
  output logic       rst_req_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rsync_q[SYNC_STAGES-1];

  wdt_cfg_t cfg;
  logic     restart, adv, tmo_hit, kill, exp_q;

  assign adv  = !(idle_i && !cfg.irun);
  assign kill = tmo_hit && cfg.en;

  wdt_guard_ctrl #(.ADDR_W(8), .CTRL_ADDR(8'h8F)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ni),
    .sfr_addr  (sfr_addr),
    .sfr_we    (sfr_we),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .kill_i    (kill),
    .cfg_o     (cfg),
    .restart_o (restart)
  );

  wdt_guard_chain #(.BASE_W(BASE_W), .PS_W(PS_W)) u_chain (
    .clk       (clk),
    .rst_n     (rst_ni),
    .adv_i     (adv),
    .restart_i (restart),
    .ps_i      (cfg.ps),
    .tmo_hit_o (tmo_hit)
  );

  wdt_guard_rstgen #(.LEN(RST_LEN)) u_rstgen (
    .clk    (clk),
    .rst_n  (rst_ni),
    .trig_i (kill),
    .req_o  (rst_req_o)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) exp_q <= 1'b0;
    else         exp_q <= tmo_hit;
  end
  assign expire_o = exp_q;

  a_r7_req_from_enabled_tmo: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(tmo_hit && cfg.en));

  a_r8_no_req_when_disabled: assert property (@(posedge clk) disable iff (!rst_ni)
    (tmo_hit && !cfg.en && !rst_req_o) |=> !rst_req_o);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    expire_o |=> !expire_o);

endmodule

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;

  localparam int B   = 3;
  localparam int LEN = 24;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       idle;
  logic [7:0] addr;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       expire, rst_req;

  int  vectors = 0;
  int  fails   = 0;
  bit  done    = 0;

  always #2.5 clk = ~clk;

  wdt_guard #(.BASE_W(B), .RST_LEN(LEN)) uut (
    .clk(clk), .rst_n(rst_n), .idle_i(idle),
    .sfr_addr(addr), .sfr_we(we), .sfr_wdata(wdata), .sfr_rdata(rdata),
    .expire_o(expire), .rst_req_o(rst_req)
  );

  function automatic int tmo_len(int ps);
    return 1 << (B + 1 + ps);
  endfunction

  function automatic logic [7:0] mk(bit en, bit clr, bit irun, int ps);
    return {en, clr, irun, 2'b00, 3'(ps)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1; idle = 1'b0;
    @(negedge clk);
    we = 1'b0; addr = 8'h8F;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
    addr = 8'h8F;
  endtask

  task automatic idle_wait(int n);
    for (int i = 0; i < n; i++) begin
      idle = 1'b0;
      @(negedge clk);
    end
  endtask

  // follow advances until the expected expiry sample
  task automatic run_tmo(int n, int start, bit irun, int idle_pct, bit en, string req);
    int cnt = start;
    bit ok  = 1'b1;
    bit hit = 1'b0;
    for (int i = 0; i < 8 * n + 8; i++) begin
      bit adv;
      idle = (($urandom % 100) < idle_pct);
      adv  = !(idle && !irun);
      @(negedge clk);
      if (adv) cnt++;
      hit = (cnt == n);
      if (expire !== hit) ok = 1'b0;
      if (rst_req !== (hit && en)) ok = 1'b0;
      if (!ok || hit) break;
    end
    if (!hit) ok = 1'b0;
    idle = 1'b0;
    chk(ok, req, cnt, n);
  endtask

  task automatic pulse_chk();
    int k = 1;
    logic [7:0] v;
    for (int i = 0; i < 30; i++) begin
      idle = 1'b0;
      @(negedge clk);
      if (rst_req) k++;
    end
    chk(k == LEN, "R7", k, LEN);
    rd(8'h8F, v);
    chk(v[7] == 1'b0, "R7", int'(v[7]), 0);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; idle = 1'b0; addr = 8'h8F; we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h8F, v);
    chk(v == 8'h00, "R1", v, 0);
    chk(!expire && !rst_req, "R1", {expire, rst_req}, 0);

    // R2 layout and address decode
    wr(8'h8F, 8'hFF);
    rd(8'h8F, v);
    chk(v == 8'hA7, "R2", v, 8'hA7);
    wr(8'h8F, 8'h00);
    wr(8'h8E, 8'hFF);
    rd(8'h8F, v);
    chk(v == 8'h00, "R2", v, 0);
    rd(8'h8E, v);
    chk(v == 8'h00, "R2", v, 0);

    // R3 interval per tap, R6 free-running repeat
    for (int ps = 0; ps < 4; ps++) begin
      wr(8'h8F, mk(0, 1, 1, ps));
      run_tmo(tmo_len(ps), 0, 1'b1, 0, 1'b0, "R3");
      run_tmo(tmo_len(ps), 0, 1'b1, 0, 1'b0, "R6");
    end

    // R8 disabled: no request, even afterwards
    wr(8'h8F, mk(0, 1, 1, 1));
    run_tmo(tmo_len(1), 0, 1'b1, 30, 1'b0, "R8");
    begin
      int highs = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (rst_req) highs++;
      end
      chk(highs == 0, "R8", highs, 0);
    end

    // R5 idle freeze versus idle run
    wr(8'h8F, mk(0, 1, 0, 2));
    run_tmo(tmo_len(2), 0, 1'b0, 40, 1'b0, "R5");
    wr(8'h8F, mk(0, 1, 1, 2));
    run_tmo(tmo_len(2), 0, 1'b1, 40, 1'b0, "R5");

    // R4 clear mid-interval
    wr(8'h8F, mk(0, 1, 1, 2));
    idle_wait(20);
    wr(8'h8F, mk(0, 1, 1, 2));
    run_tmo(tmo_len(2), 0, 1'b1, 0, 1'b0, "R4");

    // R10 plain rewrite keeps the count (20 waits + write edge = 21)
    wr(8'h8F, mk(0, 1, 1, 2));
    idle_wait(20);
    wr(8'h8F, mk(0, 0, 1, 2));
    run_tmo(tmo_len(2), 21, 1'b1, 0, 1'b0, "R10");

    // R9 select change while enabled restarts, R7 request pulse
    wr(8'h8F, mk(1, 1, 1, 0));
    idle_wait(6);
    wr(8'h8F, mk(1, 0, 1, 1));
    run_tmo(tmo_len(1), 0, 1'b1, 0, 1'b1, "R9");
    pulse_chk();

    // randomized mix
    for (int it = 0; it < 14; it++) begin
      int  ps   = $urandom % 4;
      bit  irun = $urandom % 2;
      int  pct  = $urandom % 60;
      bit  en   = $urandom % 2;
      wr(8'h8F, mk(en, 1, irun, ps));
      run_tmo(tmo_len(ps), 0, irun, pct, en, en ? "R7" : "R3");
      if (en) pulse_chk();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual 150000 cycles expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule